// File: doc/BRIEF.md
# CSR Access Side-Effect Gating Unit

This unit carries out the six control-and-status-register instructions in one cycle. It handles swap, bit-set and bit-clear, each in a register-source form and a 5-bit immediate form. It takes a 32-bit instruction word and the value of the source register. From these it drives a CSR port whose read and write strobes are separate, and it returns the old CSR contents for the destination register together with a valid flag.

The point of the unit is strobe gating. Some CSRs act on being read, for example pop-on-read queues. Others act on being written, for example interrupt acknowledges. For such registers a strobe that the instruction does not call for is a functional bug, not a harmless extra access. The unit therefore raises the read strobe only when the instruction needs the old value. It raises the write strobe only when the instruction can change the register.

Read and write happen in the same cycle, on one address, with the write value formed from the data just read. The read-modify-write is therefore a single port transaction that no other agent can split.

Top module: `csr_gate_unit`

## Requirements
- R1: For swap forms (funct3 001 and 101), the read strobe is high only when the rd field (bits 11:7) is nonzero.
- R2: For swap forms, the write strobe is always high and the write data is the operand. The operand is the source register value for 001, and the zero-extended bits 19:15 for 101.
- R3: For register set/clear forms (funct3 010 and 011), an rs1 field of zero keeps the write strobe low. Any other index raises it. The read strobe is always high.
- R4: For immediate set/clear forms (funct3 110 and 111), a zero immediate keeps the write strobe low and a nonzero one raises it. The read strobe is always high.
- R5: Set writes old OR operand. Clear writes old AND NOT operand.
- R6: The result valid is high only for an accepted instruction whose rd field is nonzero. The result value then equals the CSR read data of that same cycle.
- R7: An instruction is accepted only when its opcode (bits 6:0) is 1110011 and funct3 is not 000 or 100. Anything else raises no strobe and no result valid.
- R8: The CSR address equals instruction bits 31:20. Read, write and result all belong to the same cycle, so the access is one indivisible read-modify-write.
- R9: With the instruction-valid input low, both strobes and the result valid stay low, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used for the checking properties) |
| rstN | input | 1 | Active-low reset |
| instValid | input | 1 | Instruction word is presented this cycle |
| instWord | input | 32 | Instruction word |
| srcValue | input | XLEN | Value of the source register named in bits 19:15 |
| csrAddr | output | 12 | CSR address |
| csrRdStb | output | 1 | CSR read strobe |
| csrRdData | input | XLEN | CSR read data, combinational from csrAddr |
| csrWrStb | output | 1 | CSR write strobe |
| csrWrData | output | XLEN | CSR write data |
| resValid | output | 1 | Result for a nonzero rd is valid |
| resIdx | output | 5 | Destination register index |
| resValue | output | XLEN | Old CSR value returned to rd |

## Verification
Every output is combinational from the instruction, source value and CSR read data, so each result is due in the same cycle as its stimulus. The bench drives each stimulus just after a falling edge and samples one time unit later, before the next rising edge. The sweep covers every funct3 code, with rd and rs1 fields at zero and nonzero values, against several old-value and operand patterns. It also covers a foreign opcode and an idle cycle. Expected strobes and data are computed arithmetically from the funct3 code.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SWAP = 2'b01,
    OP_SET  = 2'b10,
    OP_CLR  = 2'b11
  } csrOpE;

  // control to datapath strobes
  typedef struct packed {
    logic  resValid;
    logic  useImm;
    csrOpE op;
  } dpCtlS;

  localparam logic [6:0] SYSTEM_OPCODE = 7'b1110011;
  localparam int INST_W = 32;
  localparam int REG_IDX_W = 5;
  localparam int CSR_ADDR_W = 12;

endpackage

// File: rtl/csr_gate_ctrl.sv
module csr_gate_ctrl
  import csr_gate_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   instValid,
  input  logic [INST_W-1:0]      instWord,
  output logic                   rdStb,
  output logic                   wrStb,
  output dpCtlS                  dpCtl,
  output logic [REG_IDX_W-1:0]   rdIdx,
  output logic [REG_IDX_W-1:0]   srcField,
  output logic [CSR_ADDR_W-1:0]  addr
);

  localparam int RD_LSB  = 7;
  localparam int F3_LSB  = RD_LSB + REG_IDX_W;
  localparam int SRC_LSB = F3_LSB + 3;
  localparam int CSR_LSB = SRC_LSB + REG_IDX_W;

  logic [6:0] opcode;
  logic [2:0] funct3;
  logic       accepted;
  logic       rdNonZero;
  logic       srcNonZero;
  csrOpE      op;

  assign opcode   = instWord[6:0];
  assign rdIdx    = instWord[F3_LSB-1:RD_LSB];
  assign funct3   = instWord[SRC_LSB-1:F3_LSB];
  assign srcField = instWord[CSR_LSB-1:SRC_LSB];
  assign addr     = instWord[INST_W-1:CSR_LSB];

  assign rdNonZero  = |rdIdx;
  // register index or immediate: both zero means "no source bits"
  assign srcNonZero = |srcField;

  assign accepted = instValid && (opcode == SYSTEM_OPCODE) && (funct3[1:0] != 2'b00);
  assign op       = accepted ? csrOpE'(funct3[1:0]) : OP_NONE;

  always_comb begin
    rdStb = 1'b0;
    wrStb = 1'b0;
    unique case (op)
      OP_SWAP: begin
        rdStb = rdNonZero;
        wrStb = 1'b1;
      end
      OP_SET, OP_CLR: begin
        rdStb = 1'b1;
        wrStb = srcNonZero;
      end
      default: begin
        rdStb = 1'b0;
        wrStb = 1'b0;
      end
    endcase
  end

  assign dpCtl.op       = op;
  assign dpCtl.useImm   = funct3[2];
  assign dpCtl.resValid = accepted && rdNonZero;

  AST_SWAP_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opcode == SYSTEM_OPCODE && funct3[1:0] == 2'b01 && rdIdx == '0) |-> !rdStb); // R1
  AST_SWAP_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opcode == SYSTEM_OPCODE && funct3[1:0] == 2'b01) |-> wrStb); // R2
  AST_SETCLR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && funct3[1] && srcField == '0) |-> !wrStb); // R3
  AST_SETCLR_READS: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && opcode == SYSTEM_OPCODE && funct3[1]) |-> rdStb); // R4
  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (opcode != SYSTEM_OPCODE) |-> (!rdStb && !wrStb && !dpCtl.resValid)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> (!rdStb && !wrStb && !dpCtl.resValid)); // R9

endmodule

// File: rtl/csr_gate_dp.sv
module csr_gate_dp
  import csr_gate_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtlS                dpCtl,
  input  logic [REG_IDX_W-1:0] srcField,
  input  logic [XLEN-1:0]      srcValue,
  input  logic [XLEN-1:0]      oldValue,
  output logic [XLEN-1:0]      wrData,
  output logic [XLEN-1:0]      resValue
);

  localparam int PAD_W = XLEN - REG_IDX_W;

  logic [XLEN-1:0] immExt;
  logic [XLEN-1:0] operand;

  assign immExt  = {{PAD_W{1'b0}}, srcField};
  assign operand = dpCtl.useImm ? immExt : srcValue;

  always_comb begin
    unique case (dpCtl.op)
      OP_SWAP: wrData = operand;
      OP_SET:  wrData = oldValue | operand;
      OP_CLR:  wrData = oldValue & ~operand;
      default: wrData = '0;
    endcase
  end

  assign resValue = dpCtl.resValid ? oldValue : '0;

  AST_SET_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.op == OP_SET) |-> ((wrData & oldValue) == oldValue)); // R5
  AST_CLR_NO_NEW: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.op == OP_CLR) |-> ((wrData & ~oldValue) == '0)); // R5
  AST_IMM_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.op == OP_SWAP && dpCtl.useImm) |-> (wrData[XLEN-1:REG_IDX_W] == '0)); // R2
  AST_RESULT_OLD: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.resValid |-> (resValue == oldValue)); // R6

endmodule

// File: rtl/csr_gate_unit.sv
module csr_gate_unit
  import csr_gate_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  instValid,
  input  logic [INST_W-1:0]     instWord,
  input  logic [XLEN-1:0]       srcValue,
  output logic [CSR_ADDR_W-1:0] csrAddr,
  output logic                  csrRdStb,
  input  logic [XLEN-1:0]       csrRdData,
  output logic                  csrWrStb,
  output logic [XLEN-1:0]       csrWrData,
  output logic                  resValid,
  output logic [REG_IDX_W-1:0]  resIdx,
  output logic [XLEN-1:0]       resValue
);

  dpCtlS                dpCtl;
  logic [REG_IDX_W-1:0] srcField;

  csr_gate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .instValid(instValid),
    .instWord (instWord),
    .rdStb    (csrRdStb),
    .wrStb    (csrWrStb),
    .dpCtl    (dpCtl),
    .rdIdx    (resIdx),
    .srcField (srcField),
    .addr     (csrAddr)
  );

  csr_gate_dp #(.XLEN(XLEN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .srcField(srcField),
    .srcValue(srcValue),
    .oldValue(csrRdData),
    .wrData  (csrWrData),
    .resValue(resValue)
  );

  assign resValid = dpCtl.resValid;

  AST_VALID_HAS_READ: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> csrRdStb); // R6
  AST_NO_EMPTY_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (csrRdStb || csrWrStb) |-> instValid); // R8

endmodule

// File: tb/csr_gate_unit_test.sv
module csr_gate_unit_test;

  localparam int XLEN = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            instValid = 1'b0;
  logic [31:0]     instWord = '0;
  logic [XLEN-1:0] srcValue = '0;
  logic [11:0]     csrAddr;
  logic            csrRdStb;
  logic [XLEN-1:0] csrRdData = '0;
  logic            csrWrStb;
  logic [XLEN-1:0] csrWrData;
  logic            resValid;
  logic [4:0]      resIdx;
  logic [XLEN-1:0] resValue;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_gate_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .srcValue(srcValue), .csrAddr(csrAddr), .csrRdStb(csrRdStb),
    .csrRdData(csrRdData), .csrWrStb(csrWrStb), .csrWrData(csrWrData),
    .resValid(resValid), .resIdx(resIdx), .resValue(resValue)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input bit v, input logic [6:0] opc, input logic [2:0] f3,
                       input logic [4:0] rd, input logic [4:0] rs1, input logic [11:0] addr,
                       input logic [XLEN-1:0] src, input logic [XLEN-1:0] old);
    bit legal;
    bit expRd;
    bit expWr;
    bit expValid;
    logic [XLEN-1:0] opnd;
    logic [XLEN-1:0] expData;
    string rdReq;
    string wrReq;
    @(negedge clk);
    instValid = v;
    instWord  = {addr, rs1, f3, rd, opc};
    srcValue  = src;
    csrRdData = old;
    #1;
    legal = v && (opc == 7'b1110011) && (f3[1:0] != 2'b00);
    opnd  = f3[2] ? XLEN'(rs1) : src;
    expRd = legal && ((f3[1:0] != 2'b01) || (rd != 0));
    expWr = legal && ((f3[1:0] == 2'b01) || (rs1 != 0));
    expValid = legal && (rd != 0);
    case (f3[1:0])
      2'b01:   expData = opnd;
      2'b10:   expData = old | opnd;
      default: expData = old & ~opnd;
    endcase
    if (!v)                 begin rdReq = "R9"; wrReq = "R9"; end
    else if (!legal)        begin rdReq = "R7"; wrReq = "R7"; end
    else if (f3[1:0] == 2'b01) begin rdReq = "R1"; wrReq = "R2"; end
    else if (f3[2])         begin rdReq = "R4"; wrReq = "R4"; end
    else                    begin rdReq = "R3"; wrReq = "R3"; end
    check(csrRdStb === expRd, rdReq, "read strobe", XLEN'(csrRdStb), XLEN'(expRd));
    check(csrWrStb === expWr, wrReq, "write strobe", XLEN'(csrWrStb), XLEN'(expWr));
    check(resValid === expValid, legal ? "R6" : rdReq, "result valid", XLEN'(resValid), XLEN'(expValid));
    if (expWr)
      check(csrWrData === expData, (f3[1:0] == 2'b01) ? "R2" : "R5", "write data", csrWrData, expData);
    if (expValid) begin
      check(resValue === old, "R6", "result value", resValue, old);
      check(resIdx === rd, "R6", "result index", XLEN'(resIdx), XLEN'(rd));
    end
    if (legal)
      check(csrAddr === addr, "R8", "csr address", XLEN'(csrAddr), XLEN'(addr));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [XLEN-1:0] olds [3];
    logic [XLEN-1:0] srcs [3];
    logic [4:0] rds [3];
    logic [4:0] rs1s [4];
    olds[0] = 32'h0000_0000; olds[1] = 32'hA5A5_F00F; olds[2] = 32'hFFFF_FFFF;
    srcs[0] = 32'h0000_0000; srcs[1] = 32'h0F0F_1234; srcs[2] = 32'h8000_001F;
    rds[0] = 5'd0; rds[1] = 5'd1; rds[2] = 5'd31;
    rs1s[0] = 5'd0; rs1s[1] = 5'd1; rs1s[2] = 5'd10; rs1s[3] = 5'd31;

    // reset state: idle input, strobes quiet (R9)
    repeat (2) @(negedge clk);
    #1;
    check(!csrRdStb && !csrWrStb && !resValid, "R9", "reset quiet",
          XLEN'({csrRdStb, csrWrStb, resValid}), '0);
    rstN = 1'b1;

    for (int f = 0; f < 8; f++)
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 4; b++)
          for (int o = 0; o < 3; o++)
            apply(1'b1, 7'b1110011, 3'(f), rds[a], rs1s[b], 12'(12'h300 + f*16 + a),
                  srcs[(o + b) % 3], olds[o]);

    // foreign opcode with CSR-like fields (R7)
    apply(1'b1, 7'b0110011, 3'b001, 5'd3, 5'd4, 12'h340, 32'h1234, 32'h55);
    apply(1'b1, 7'b1110010, 3'b011, 5'd3, 5'd4, 12'h340, 32'h1234, 32'h55);
    // idle cycle with a full instruction on the bus (R9)
    apply(1'b0, 7'b1110011, 3'b010, 5'd7, 5'd9, 12'hC00, 32'hFFFF, 32'h1);
    // clear with all-ones operand and set of all-ones (R5)
    apply(1'b1, 7'b1110011, 3'b011, 5'd2, 5'd2, 12'h7C0, 32'hFFFF_FFFF, 32'hDEAD_BEEF);
    apply(1'b1, 7'b1110011, 3'b110, 5'd2, 5'd31, 12'h7C1, 32'h0, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule